// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block keeps the code segment and instruction pointer of a 16-bit processor and turns segment:offset pairs into 20-bit physical addresses. A far (inter-segment) jump replaces both registers in the same clock edge. A near (intra-segment) jump rewrites only the instruction pointer. A sequential advance steps the instruction pointer by an instruction length. The fetch address comes straight from the two registers, so it is valid in every cycle, including the first cycle after reset.

A second, purely combinational path translates data accesses. It takes a segment-register value and an offset and applies the same rule as the fetch path: the segment is shifted left by four bits, and the offset is added to it. Only offset bits [15:4] enter the carry chain, and offset bits [3:0] pass straight through to the low nibble. Any carry beyond bit 19 is dropped, so an address past 0xFFFFF wraps to the bottom of the 1 MiB space.

Top module: `seg_addr_gen`

## Requirements
- R1: `data_addr` equals (`data_seg` × 16 + `data_off`) modulo 2^20 in the same cycle; segment 0x8880 with offset 0x0440 gives 0x88C40.
- R2: Bits [3:0] of every generated address (fetch and data) equal bits [3:0] of the offset used.
- R3: A sum above 0xFFFFF wraps: segment 0xFFFF with offset 0x0010 gives 0x00000, and with offset 0xFFFF gives 0x0FFEF.
- R4: While `rst` is high at a clock edge, the code segment loads `RESET_CS` (default 0xFFFF) and the instruction pointer loads `RESET_IP` (default 0x0000). In the first cycle after release, `fetch_addr` is 0xFFFF0.
- R5: When `far_jmp` is high at an edge, the code segment becomes `far_seg` and the instruction pointer becomes `far_off` after that edge. From code segment 0x0000, a far jump to 0x0C70:0x0004 gives a fetch address of 0x0C704.
- R6: When `near_jmp` is high at an edge and `far_jmp` is low, the instruction pointer becomes `near_off` and the code segment is unchanged.
- R7: When `adv` is high at an edge and no jump is requested, the instruction pointer becomes (IP + `adv_len`) modulo 2^16 and the code segment is unchanged.
- R8: Priority is far jump over near jump over advance; a lower-priority request in the same cycle has no effect.
- R9: `fetch_addr` is the translation of the current `cs_out`:`ip_out` by the rule of R1.
- R10: With no request asserted, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| far_jmp | input | 1 | Load segment and offset together |
| far_seg | input | 16 | Target code segment of a far jump |
| far_off | input | 16 | Target offset of a far jump |
| near_jmp | input | 1 | Load instruction pointer only |
| near_off | input | 16 | Target offset of a near jump |
| adv | input | 1 | Step instruction pointer sequentially |
| adv_len | input | 4 | Instruction length in bytes for the step |
| data_seg | input | 16 | Segment-register value of a data access |
| data_off | input | 16 | Offset of a data access |
| cs_out | output | 16 | Current code segment |
| ip_out | output | 16 | Current instruction pointer |
| fetch_addr | output | 20 | Physical fetch address |
| data_addr | output | 20 | Physical data address |

## Verification
The bench targets the carry boundary between offset bit 3 and bit 4, where a design that added all 16 offset bits into a shifted segment would still agree. A design that dropped or misaligned the low nibble, however, would corrupt bits [3:0]. The wrap cases at segment 0xFFFF catch an adder that is one bit too wide, which would leak a carry and produce a 21-bit result or a wrong low address. The jump sequences check the known far-jump example, instruction-pointer overflow on a step, and every pairing of simultaneous requests. A wrong priority order, or a near jump that also touched the segment, shows up there as a wrong `cs_out` or `ip_out`.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int SHIFT  = 4;
    localparam int ADDR_W = SEG_W + SHIFT;
    localparam int HI_W   = ADDR_W - SHIFT;
    localparam int LEN_W  = 4;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [ADDR_W-1:0] paddr_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        seg_t cs;
        off_t ip;
    } cs_ip_t;

    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_STEP = 2'd1,
        UPD_NEAR = 2'd2,
        UPD_FAR  = 2'd3
    } upd_e;

    function automatic upd_e pick_update(input logic far_q, input logic near_q,
                                         input logic step_q);
        if (far_q)       return UPD_FAR;
        else if (near_q) return UPD_NEAR;
        else if (step_q) return UPD_STEP;
        else             return UPD_HOLD;
    endfunction

endpackage

// File: rtl/seg_translate.sv
module seg_translate
    import seg_addr_pkg::*;
(
    input  seg_t   seg_i,
    input  off_t   off_i,
    output paddr_t addr_o
);
    logic [HI_W-1:0] upper_sum;

    always_comb begin
        upper_sum = seg_i + HI_W'(off_i[OFF_W-1:SHIFT]);
        addr_o    = {upper_sum, off_i[SHIFT-1:0]};
    end

    always_comb begin
        assert_low_nibble_R2: assert (addr_o[SHIFT-1:0] === off_i[SHIFT-1:0] || $isunknown(off_i))
            else $error("low nibble not passed through");
    end
endmodule

// File: rtl/seg_pc_regs.sv
module seg_pc_regs
    import seg_addr_pkg::*;
#(
    parameter seg_t RESET_CS = 16'hFFFF,
    parameter off_t RESET_IP = 16'h0000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   far_jmp,
    input  seg_t   far_seg,
    input  off_t   far_off,
    input  logic   near_jmp,
    input  off_t   near_off,
    input  logic   adv,
    input  len_t   adv_len,
    output cs_ip_t state_o
);
    cs_ip_t state_q, state_d;
    upd_e   sel;

    always_comb begin
        sel     = pick_update(far_jmp, near_jmp, adv);
        state_d = state_q;
        unique case (sel)
            UPD_FAR:  begin state_d.cs = far_seg; state_d.ip = far_off; end
            UPD_NEAR: state_d.ip = near_off;
            UPD_STEP: state_d.ip = state_q.ip + OFF_W'(adv_len);
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.cs <= RESET_CS;
            state_q.ip <= RESET_IP;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    assert_far_load_R5: assert property (@(posedge clk) disable iff (rst)
        far_jmp |=> (state_q.cs == $past(far_seg) && state_q.ip == $past(far_off)));

    assert_near_keep_cs_R6: assert property (@(posedge clk) disable iff (rst)
        (near_jmp && !far_jmp) |=> ($stable(state_q.cs) && state_q.ip == $past(near_off)));

    assert_step_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (adv && !near_jmp && !far_jmp) |=>
            ($stable(state_q.cs) && state_q.ip == OFF_W'($past(state_q.ip) + $past(adv_len))));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!adv && !near_jmp && !far_jmp) |=> ($stable(state_q.cs) && $stable(state_q.ip)));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter logic [15:0] RESET_CS = 16'hFFFF,
    parameter logic [15:0] RESET_IP = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              far_jmp,
    input  logic [SEG_W-1:0]  far_seg,
    input  logic [OFF_W-1:0]  far_off,
    input  logic              near_jmp,
    input  logic [OFF_W-1:0]  near_off,
    input  logic              adv,
    input  logic [LEN_W-1:0]  adv_len,
    input  logic [SEG_W-1:0]  data_seg,
    input  logic [OFF_W-1:0]  data_off,
    output logic [SEG_W-1:0]  cs_out,
    output logic [OFF_W-1:0]  ip_out,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] data_addr
);
    cs_ip_t pc;

    seg_pc_regs #(.RESET_CS(RESET_CS), .RESET_IP(RESET_IP)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .far_jmp  (far_jmp),
        .far_seg  (far_seg),
        .far_off  (far_off),
        .near_jmp (near_jmp),
        .near_off (near_off),
        .adv      (adv),
        .adv_len  (adv_len),
        .state_o  (pc)
    );

    seg_translate u_fetch_xlat (
        .seg_i  (pc.cs),
        .off_i  (pc.ip),
        .addr_o (fetch_addr)
    );

    seg_translate u_data_xlat (
        .seg_i  (data_seg),
        .off_i  (data_off),
        .addr_o (data_addr)
    );

    assign cs_out = pc.cs;
    assign ip_out = pc.ip;

    assert_far_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        far_jmp |=> (fetch_addr[SHIFT-1:0] == $past(far_off[SHIFT-1:0])));
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        far_jmp, near_jmp, adv;
    logic [15:0] far_seg, far_off, near_off, data_seg, data_off;
    logic [3:0]  adv_len;
    logic [15:0] cs_out, ip_out;
    logic [19:0] fetch_addr, data_addr;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    seg_addr_gen u_dut (
        .clk(clk), .rst(rst),
        .far_jmp(far_jmp), .far_seg(far_seg), .far_off(far_off),
        .near_jmp(near_jmp), .near_off(near_off),
        .adv(adv), .adv_len(adv_len),
        .data_seg(data_seg), .data_off(data_off),
        .cs_out(cs_out), .ip_out(ip_out),
        .fetch_addr(fetch_addr), .data_addr(data_addr)
    );

    function automatic logic [19:0] ref_phys(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] wide;
        wide = {1'b0, s, 4'h0} + {5'h0, o};
        return wide[19:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        far_jmp = 0; near_jmp = 0; adv = 0;
        far_seg = 0; far_off = 0; near_off = 0; adv_len = 0;
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs(); data_seg = 0; data_off = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R4 cs", 32'(cs_out), 32'h0000FFFF);
        check("R4 ip", 32'(ip_out), 32'h0);
        check("R4 fetch", 32'(fetch_addr), 32'h000FFFF0);
    endtask

    task automatic t_data_xlat();
        logic [15:0] segs [6] = '{16'h8880, 16'h0000, 16'h1234, 16'hA00F, 16'h7FFF, 16'h0C70};
        logic [15:0] offs [6] = '{16'h0440, 16'hFFFF, 16'h000F, 16'h001F, 16'h8EEF, 16'h0004};
        data_seg = 16'h8880; data_off = 16'h0440; #1;
        check("R1 example", 32'(data_addr), 32'h00088C40);
        for (int i = 0; i < 6; i++) begin
            data_seg = segs[i]; data_off = offs[i]; #1;
            check("R1 pattern", 32'(data_addr), 32'(ref_phys(segs[i], offs[i])));
            check("R2 data nibble", 32'(data_addr[3:0]), 32'(offs[i][3:0]));
        end
    endtask

    task automatic t_wrap();
        data_seg = 16'hFFFF; data_off = 16'h0010; #1;
        check("R3 wrap zero", 32'(data_addr), 32'h0);
        data_off = 16'hFFFF; #1;
        check("R3 wrap top", 32'(data_addr), 32'h0000FFEF);
    endtask

    task automatic t_far_jump();
        far_jmp = 1; far_seg = 16'h0000; far_off = 16'h0100;
        edge_step();
        check("R5 cs zero", 32'(cs_out), 32'h0);
        far_jmp = 1; far_seg = 16'h0C70; far_off = 16'h0004;
        edge_step();
        check("R5 cs", 32'(cs_out), 32'h0C70);
        check("R5 ip", 32'(ip_out), 32'h0004);
        check("R9 fetch", 32'(fetch_addr), 32'h0000C704);
        check("R2 fetch nibble", 32'(fetch_addr[3:0]), 32'h4);
    endtask

    task automatic t_near_jump();
        near_jmp = 1; near_off = 16'hBEEF;
        edge_step();
        check("R6 cs kept", 32'(cs_out), 32'h0C70);
        check("R6 ip", 32'(ip_out), 32'hBEEF);
        check("R9 fetch", 32'(fetch_addr), 32'(ref_phys(16'h0C70, 16'hBEEF)));
    endtask

    task automatic t_advance();
        near_jmp = 1; near_off = 16'hFFFE;
        edge_step();
        adv = 1; adv_len = 4'd3;
        edge_step();
        check("R7 ip wrap", 32'(ip_out), 32'h0001);
        check("R7 cs kept", 32'(cs_out), 32'h0C70);
        adv = 1; adv_len = 4'd15;
        edge_step();
        check("R7 ip step", 32'(ip_out), 32'h0010);
    endtask

    task automatic t_priority();
        far_jmp = 1; far_seg = 16'h2000; far_off = 16'h0050;
        adv = 1; adv_len = 4'd7;
        edge_step();
        check("R8 far over adv ip", 32'(ip_out), 32'h0050);
        check("R8 far over adv cs", 32'(cs_out), 32'h2000);
        far_jmp = 1; far_seg = 16'h3000; far_off = 16'h0060;
        near_jmp = 1; near_off = 16'h9999;
        edge_step();
        check("R8 far over near ip", 32'(ip_out), 32'h0060);
        check("R8 far over near cs", 32'(cs_out), 32'h3000);
        near_jmp = 1; near_off = 16'h4444; adv = 1; adv_len = 4'd2;
        edge_step();
        check("R8 near over adv", 32'(ip_out), 32'h4444);
    endtask

    task automatic t_idle();
        repeat (3) edge_step();
        check("R10 cs hold", 32'(cs_out), 32'h3000);
        check("R10 ip hold", 32'(ip_out), 32'h4444);
        check("R9 fetch hold", 32'(fetch_addr), 32'h00034444);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_data_xlat();
                t_wrap();
                t_far_jump();
                t_near_jump();
                t_advance();
                t_priority();
                t_idle();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule